// File: doc/BRIEF.md
# Block-Transfer DMA Channel with Non-Maskable Suspend

This block is one DMA channel that copies data between a memory address and a peripheral register address, one block per activating request. A block is a fixed number of units, each unit being one byte or one 16-bit word. Every unit is a read phase followed by a write phase on a simple request/grant bus master port. Direction, unit size, and whether the memory pointer counts up or down are set at configuration time. The peripheral address stays fixed and always lies in the top 256 bytes of the address space. The memory pointer can reach the whole space, in either a 20-bit or a 24-bit addressing mode.

The channel has two enables. The run enable is set by configuration and is cleared by the channel after the last block. The master enable is set by a separate strobe. A rising edge on the non-maskable interrupt input lets the unit in flight finish its write, then clears the master enable and stops the channel, even partway through a block. After the master enable is set again, the next activating request finishes only what was left of the interrupted block. Requests that arrive while the channel is stopped are dropped and are not remembered. A request that arrives while a block is still moving is also dropped, and it is flagged as a protocol error.

Top module: `blk_dma_chan`

## Requirements
- R1: A configuration load while idle sets run enable to 1, sets the block size counter to the configured size and sets the block count to the configured count. It leaves the master enable unchanged. A master-set strobe sets the master enable to 1.
- R2: A request accepted while idle with both enables at 1 pulses act_clr once. Each unit is then a read at the source address followed by a write of that read data to the destination address. Direction 0 copies memory to peripheral and 1 copies peripheral to memory. A byte unit writes only the low 8 read bits, with the upper bits zero.
- R3: After each unit the memory pointer moves by 1 for bytes or 2 for words, upward when cfg_dec is 0 and downward when it is 1. In 20-bit mode (cfg_wide=0) the pointer wraps within 0x00000 to 0xFFFFF. The peripheral address is 0xFFFF00 plus the 8-bit offset in 24-bit mode, and 0x0FFF00 plus the offset in 20-bit mode.
- R4: The block size counter decrements after every unit. When it reaches zero it reloads the configured size and the block count decrements. One accepted request moves the units that remain in the current block and then returns to idle.
- R5: When the last unit of the last block completes, run enable clears. tend_irq then pulses for one cycle if cfg_irq_en is 1 and stays low if it is 0.
- R6: After a rising nmi edge during a block, the unit in flight completes its write. Then the master enable becomes 0, no further bus request is made, act_clr pulses, and the block size counter keeps the number of units still remaining.
- R7: While the master enable is 0, an activating request causes no bus request, no act_clr and no counter change. It is not held pending: setting the master enable afterwards starts nothing.
- R8: After a mid-block stop and a master-set, the next request moves only the remaining units of the interrupted block. The request after that moves a full block.
- R9: A request that arrives while a block is moving pulses overrun one cycle later and is dropped. The block in progress moves exactly its expected units.
- R10: After reset the channel is idle with both enables at 0 and with no bus request, no tend_irq, no act_clr and no overrun.
- R11: A rising nmi edge while idle clears the master enable on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration and set run enable (idle only) |
| cfg_mar | input | AW | Start memory address |
| cfg_io | input | 8 | Peripheral address offset within the top 256 bytes |
| cfg_size | input | SW | Units per block (nonzero) |
| cfg_count | input | CW | Number of blocks (nonzero) |
| cfg_dir | input | 1 | 0: memory to peripheral, 1: peripheral to memory |
| cfg_word | input | 1 | 1: 16-bit units, 0: byte units |
| cfg_dec | input | 1 | 1: memory pointer counts down |
| cfg_wide | input | 1 | 1: 24-bit addressing, 0: 20-bit addressing |
| cfg_irq_en | input | 1 | Enables the end-of-transfer pulse |
| master_set | input | 1 | Sets the master enable |
| act_req | input | 1 | Activating request pulse |
| nmi | input | 1 | Non-maskable interrupt level, edge-detected |
| bus_req | output | 1 | Bus phase request |
| bus_we | output | 1 | 1: write phase, 0: read phase |
| bus_word | output | 1 | Phase is a 16-bit access |
| bus_addr | output | AW | Phase address |
| bus_wdata | output | DW | Write data |
| bus_gnt | input | 1 | Grant; completes the current phase |
| bus_rdata | input | DW | Read data, valid with grant in a read phase |
| act_clr | output | 1 | Pulse that clears the activating request flag |
| tend_irq | output | 1 | End-of-transfer interrupt pulse |
| overrun | output | 1 | Pulse: request arrived while busy |
| xfer_en | output | 1 | Run enable |
| master_en | output | 1 | Master enable |
| blk_left | output | SW | Block size counter |
| blk_count | output | CW | Remaining block count |
| mar | output | AW | Current memory pointer |

## Verification
The bench runs word copies to the peripheral with an upward pointer, then byte copies from the peripheral with a downward pointer in 20-bit mode that crosses address zero. This tells apart the direction, step and wrap logic. Full-block requests are contrasted with one block that an nmi edge cuts after two units and that is then finished by a later request. This shows that the block size counter carries the remainder and that dropped requests leave no trace. A request injected mid-block, and the final block with the interrupt enabled and then disabled, separate the overrun path from the end-of-transfer path.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_st_e;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 24,
  parameter int NW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] mar_in,
  input  logic [7:0]    io_in,
  input  logic          wide_in,
  input  logic          word_in,
  input  logic          dec_in,
  input  logic          step,
  output logic [AW-1:0] mar,
  output logic [AW-1:0] io_addr
);
  localparam logic [AW-1:0] NMASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

  logic [7:0]    io_q;
  logic          wide_q, word_q, dec_q;
  logic [AW-1:0] stepv, nxt;

  assign stepv = {{(AW-2){1'b0}}, word_q, ~word_q};
  assign nxt   = dec_q ? (mar - stepv) : (mar + stepv);
  assign io_addr = wide_q ? {{(AW-8){1'b1}}, io_q}
                          : {{(AW-NW){1'b0}}, {(NW-8){1'b1}}, io_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0; io_q <= '0; wide_q <= 1'b0; word_q <= 1'b0; dec_q <= 1'b0;
    end else if (load) begin
      mar    <= wide_in ? mar_in : (mar_in & NMASK);
      io_q   <= io_in;
      wide_q <= wide_in;
      word_q <= word_in;
      dec_q  <= dec_in;
    end else if (step) begin
      mar <= wide_q ? nxt : (nxt & NMASK);
    end
  end

  // R3: every completed unit moves the memory pointer
  a_r3_mar_moves: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (mar != $past(mar)));
endmodule

// File: rtl/dma_blk_cnt.sv
module dma_blk_cnt #(
  parameter int SW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] size_in,
  input  logic [CW-1:0] count_in,
  input  logic          unit_done,
  output logic [SW-1:0] left,
  output logic [CW-1:0] count,
  output logic          blk_end,
  output logic          xfer_last
);
  logic [SW-1:0] init_q;

  assign blk_end   = (left == SW'(1));
  assign xfer_last = blk_end && (count == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0; count <= '0; init_q <= '0;
    end else if (load) begin
      left <= size_in; init_q <= size_in; count <= count_in;
    end else if (unit_done) begin
      if (blk_end) begin
        left  <= init_q;
        count <= count - CW'(1);
      end else begin
        left <= left - SW'(1);
      end
    end
  end

  // R4: a finished block reloads the size counter
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (unit_done && blk_end && !load) |=> (left == init_q));
  // R4: a unit inside a block counts down by one
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (unit_done && !blk_end && !load) |=> (left == $past(left) - SW'(1)));
endmodule

// File: rtl/blk_dma_chan.sv
module blk_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 24,
  parameter int NW = 20,
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_mar,
  input  logic [7:0]    cfg_io,
  input  logic [SW-1:0] cfg_size,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_dir,
  input  logic          cfg_word,
  input  logic          cfg_dec,
  input  logic          cfg_wide,
  input  logic          cfg_irq_en,
  input  logic          master_set,
  input  logic          act_req,
  input  logic          nmi,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          act_clr,
  output logic          tend_irq,
  output logic          overrun,
  output logic          xfer_en,
  output logic          master_en,
  output logic [SW-1:0] blk_left,
  output logic [CW-1:0] blk_count,
  output logic [AW-1:0] mar
);
  dma_st_e       st;
  logic          nmi_q, nmi_pend, dir_q, word_q, irq_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] io_addr;
  logic          busy, load, nmi_edge, halt, start, unit_done, blk_end, xfer_last;

  assign busy      = (st != ST_IDLE);
  assign load      = cfg_load && !busy;
  assign nmi_edge  = nmi && !nmi_q;
  assign halt      = nmi_edge || nmi_pend;
  assign start     = !busy && act_req && xfer_en && master_en && !halt;
  assign unit_done = (st == ST_WR) && bus_gnt;

  dma_addr_gen #(.AW(AW), .NW(NW)) u_addr (
    .clk(clk), .rst(rst), .load(load), .mar_in(cfg_mar), .io_in(cfg_io),
    .wide_in(cfg_wide), .word_in(cfg_word), .dec_in(cfg_dec),
    .step(unit_done), .mar(mar), .io_addr(io_addr));

  dma_blk_cnt #(.SW(SW), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .size_in(cfg_size), .count_in(cfg_count),
    .unit_done(unit_done), .left(blk_left), .count(blk_count),
    .blk_end(blk_end), .xfer_last(xfer_last));

  assign bus_req   = busy;
  assign bus_we    = (st == ST_WR);
  assign bus_word  = word_q;
  assign bus_addr  = ((st == ST_WR) ^ dir_q) ? io_addr : mar;
  assign bus_wdata = word_q ? data_q : {{(DW-8){1'b0}}, data_q[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; nmi_q <= 1'b0; nmi_pend <= 1'b0;
      xfer_en <= 1'b0; master_en <= 1'b0;
      dir_q <= 1'b0; word_q <= 1'b0; irq_q <= 1'b0; data_q <= '0;
      act_clr <= 1'b0; tend_irq <= 1'b0; overrun <= 1'b0;
    end else begin
      nmi_q    <= nmi;
      act_clr  <= 1'b0;
      tend_irq <= 1'b0;
      overrun  <= busy && act_req;
      if (nmi_edge && busy) nmi_pend <= 1'b1;
      if (master_set) master_en <= 1'b1;
      if (load) begin
        xfer_en <= 1'b1; dir_q <= cfg_dir; word_q <= cfg_word; irq_q <= cfg_irq_en;
      end
      unique case (st)
        ST_IDLE: begin
          if (halt) begin
            master_en <= 1'b0; nmi_pend <= 1'b0;
          end else if (start) begin
            st <= ST_RD; act_clr <= 1'b1;
          end
        end
        ST_RD: begin
          if (bus_gnt) begin
            data_q <= bus_rdata; st <= ST_WR;
          end
        end
        ST_WR: begin
          if (bus_gnt) begin
            if (halt) begin
              master_en <= 1'b0; nmi_pend <= 1'b0;
            end
            if (xfer_last) begin
              xfer_en <= 1'b0; tend_irq <= irq_q; st <= ST_IDLE;
            end else if (halt) begin
              st <= ST_IDLE; act_clr <= !blk_end;
            end else if (blk_end) begin
              st <= ST_IDLE;
            end else begin
              st <= ST_RD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: a stop request takes effect right after the unit's write
  a_r6_nmi_halt: assert property (@(posedge clk) disable iff (rst)
    (unit_done && halt) |=> (!master_en && !bus_req));
  // R7: a channel without master enable never starts
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    (!busy && !master_en) |=> !bus_req);
  // R5: end-of-transfer pulse only once the run enable is down
  a_r5_tend: assert property (@(posedge clk) disable iff (rst)
    tend_irq |-> !xfer_en);
  // R9: a request during a block is flagged
  a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
    (busy && act_req) |=> overrun);
  // R2: a write phase always follows a read phase
  a_r2_rd_then_wr: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> $past(bus_req));
endmodule

// File: tb/test_blk_dma_chan.sv
module test_blk_dma_chan;
  localparam int AW = 24, DW = 16, SW = 8, CW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_load = 0, cfg_dir = 0, cfg_word = 0, cfg_dec = 0, cfg_wide = 0, cfg_irq_en = 0;
  logic [AW-1:0] cfg_mar = '0;
  logic [7:0] cfg_io = '0;
  logic [SW-1:0] cfg_size = '0;
  logic [CW-1:0] cfg_count = '0;
  logic master_set = 0, act_req = 0, nmi = 0, bus_gnt = 0;
  logic bus_req, bus_we, bus_word, act_clr, tend_irq, overrun, xfer_en, master_en;
  logic [AW-1:0] bus_addr, mar;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [SW-1:0] blk_left;
  logic [CW-1:0] blk_count;

  int tests = 0, fails = 0;
  int wr_seen = 0, clr_seen = 0, tend_seen = 0, ovr_seen = 0, req_seen = 0;
  bit done = 0;
  logic [AW+DW-1:0] q[$];

  // model state
  logic [AW-1:0] m_mar, m_io;
  logic [SW-1:0] m_left, m_size;
  logic [CW-1:0] m_cnt;
  logic m_dir, m_word, m_dec, m_wide;

  always #2 clk = ~clk;

  blk_dma_chan i_blk_dma_chan (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_mar(cfg_mar), .cfg_io(cfg_io),
    .cfg_size(cfg_size), .cfg_count(cfg_count), .cfg_dir(cfg_dir), .cfg_word(cfg_word),
    .cfg_dec(cfg_dec), .cfg_wide(cfg_wide), .cfg_irq_en(cfg_irq_en),
    .master_set(master_set), .act_req(act_req), .nmi(nmi),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .act_clr(act_clr), .tend_irq(tend_irq), .overrun(overrun), .xfer_en(xfer_en),
    .master_en(master_en), .blk_left(blk_left), .blk_count(blk_count), .mar(mar));

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ {a[19:16], 12'h5A3} ^ 16'h3C00;
  endfunction

  assign bus_rdata = mem_val(bus_addr);
  always @(posedge clk) bus_gnt <= bus_req && !bus_gnt;

  // monitor: scoreboard and pulse counters
  always @(negedge clk) begin
    if (!rst) begin
      if (act_clr) clr_seen++;
      if (tend_irq) tend_seen++;
      if (overrun) ovr_seen++;
      if (bus_req) req_seen++;
      if (bus_req && bus_we && bus_gnt) begin
        tests++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected write addr=%h data=%h expected none", bus_addr, bus_wdata);
        end else begin
          logic [AW+DW-1:0] e;
          e = q.pop_front();
          if ({bus_addr, bus_wdata} !== e) begin
            fails++;
            $display("FAIL R2/R3 write addr/data=%h expected %h", {bus_addr, bus_wdata}, e);
          end
        end
        wr_seen++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [AW-1:0] a, input logic [7:0] io, input logic [SW-1:0] sz,
                           input logic [CW-1:0] cn, input logic d, w, dc, wd, ie);
    @(negedge clk);
    cfg_mar = a; cfg_io = io; cfg_size = sz; cfg_count = cn;
    cfg_dir = d; cfg_word = w; cfg_dec = dc; cfg_wide = wd; cfg_irq_en = ie; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    m_mar = wd ? a : (a & 24'h0FFFFF);
    m_io = wd ? {16'hFFFF, io} : {4'h0, 12'hFFF, io};
    m_left = sz; m_size = sz; m_cnt = cn;
    m_dir = d; m_word = w; m_dec = dc; m_wide = wd;
  endtask

  task automatic push_units(input int k);
    for (int i = 0; i < k; i++) begin
      logic [AW-1:0] src, dst, st;
      logic [DW-1:0] dv;
      src = m_dir ? m_io : m_mar;
      dst = m_dir ? m_mar : m_io;
      dv = mem_val(src);
      if (!m_word) dv = {8'h00, dv[7:0]};
      q.push_back({dst, dv});
      st = m_word ? 24'd2 : 24'd1;
      m_mar = m_dec ? m_mar - st : m_mar + st;
      if (!m_wide) m_mar = m_mar & 24'h0FFFFF;
      if (m_left == 1) begin m_left = m_size; m_cnt = m_cnt - 1; end
      else m_left = m_left - 1;
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); act_req = 1;
    @(negedge clk); act_req = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || bus_req);
  endtask

  // driver: push expected units, fire request, optionally stop or overrun mid-block
  task automatic run_req(input int k, input bit do_nmi, input bit do_ovr);
    int base;
    base = wr_seen;
    push_units(k);
    pulse_req();
    if (do_nmi) begin
      wait (wr_seen == base + 1);
      @(negedge clk); nmi = 1;
    end
    if (do_ovr) begin
      wait (wr_seen == base + 1);
      @(negedge clk); act_req = 1;
      @(negedge clk); act_req = 0;
    end
    wait_idle();
  endtask

  task automatic set_master();
    @(negedge clk); master_set = 1;
    @(negedge clk); master_set = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r0, c0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 bus_req", {31'b0, bus_req}, 0);
    chk("R10 enables", {30'b0, xfer_en, master_en}, 0);
    chk("R10 pulses", {29'b0, tend_irq, act_clr, overrun}, 0);

    // R1 configuration: 24-bit, word, up, mem->io, 4 units x 3 blocks
    configure(24'h001000, 8'h40, 8'd4, 16'd3, 0, 1, 0, 1, 1);
    chk("R1 xfer_en", {31'b0, xfer_en}, 1);
    chk("R1 master_en unchanged", {31'b0, master_en}, 0);
    chk("R1 blk_left", {24'b0, blk_left}, 4);
    chk("R1 blk_count", {16'b0, blk_count}, 3);

    // R7 request with master enable off is dropped
    r0 = req_seen; c0 = clr_seen;
    pulse_req(); repeat (6) @(negedge clk);
    chk("R7 no bus request", req_seen - r0, 0);
    chk("R7 no act_clr", clr_seen - c0, 0);
    chk("R7 counter unchanged", {24'b0, blk_left}, 4);
    set_master();
    chk("R1 master_en set", {31'b0, master_en}, 1);
    repeat (6) @(negedge clk);
    chk("R7 not pending", req_seen - r0, 0);

    // R2 R3 R4 one full block
    c0 = clr_seen;
    run_req(4, 0, 0);
    chk("R2 act_clr once", clr_seen - c0, 1);
    chk("R4 blk_left reload", {24'b0, blk_left}, {24'b0, m_left});
    chk("R4 blk_count", {16'b0, blk_count}, {16'b0, m_cnt});
    chk("R3 mar up word", {8'b0, mar}, {8'b0, m_mar});

    // R6 nmi mid-block after two units
    c0 = clr_seen;
    run_req(2, 1, 0);
    r0 = req_seen;
    repeat (6) @(negedge clk);
    chk("R6 master_en cleared", {31'b0, master_en}, 0);
    chk("R6 remaining units", {24'b0, blk_left}, 2);
    chk("R6 no more requests", req_seen - r0, 0);
    chk("R6 act_clr start+halt", clr_seen - c0, 2);
    chk("R6 mar", {8'b0, mar}, {8'b0, m_mar});

    // R7 request while stopped is dropped, not pending
    c0 = clr_seen;
    pulse_req(); repeat (4) @(negedge clk);
    nmi = 0;
    chk("R7 dropped while stopped", req_seen - r0, 0);
    set_master(); repeat (6) @(negedge clk);
    chk("R7 nothing after master set", req_seen - r0, 0);
    chk("R7 no act_clr", clr_seen - c0, 0);
    chk("R7 counter kept", {24'b0, blk_left}, 2);

    // R8 resume remainder of the block
    run_req(2, 0, 0);
    chk("R8 remainder then reload", {24'b0, blk_left}, 4);
    chk("R8 blk_count", {16'b0, blk_count}, 1);

    // R9 + R5 last block with overrun injected
    c0 = ovr_seen; r0 = tend_seen;
    run_req(4, 0, 1);
    repeat (2) @(negedge clk);
    chk("R9 overrun flagged", ovr_seen - c0, 1);
    chk("R8 full block moved", q.size(), 0);
    chk("R5 tend pulse", tend_seen - r0, 1);
    chk("R5 xfer_en cleared", {31'b0, xfer_en}, 0);
    chk("R4 blk_count zero", {16'b0, blk_count}, 0);

    // R3 R5: 20-bit, byte, down, io->mem, irq disabled, wrap across zero
    configure(24'h000001, 8'h7E, 8'd3, 16'd1, 1, 0, 1, 0, 0);
    r0 = tend_seen;
    run_req(3, 0, 0);
    repeat (2) @(negedge clk);
    chk("R3 mar wraps 20-bit", {8'b0, mar}, 32'h000FFFFE);
    chk("R5 no tend when disabled", tend_seen - r0, 0);
    chk("R5 xfer_en cleared", {31'b0, xfer_en}, 0);

    // R11 nmi edge while idle
    chk("R11 master before", {31'b0, master_en}, 1);
    @(negedge clk); nmi = 1;
    @(negedge clk);
    chk("R11 master cleared", {31'b0, master_en}, 0);
    nmi = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule